// File: doc/BRIEF.md
# Framed Configuration Loader for Filter Coefficients and Output Controls

This block takes a filter's configuration in through one narrow 12-bit word port that runs on its own configuration clock. A host lowers an active-low load strobe. It then presents a frame of five words on consecutive clock edges: one target address, followed by four data words. The address picks one of three kinds of target:

- a coefficient set, which places one 12-bit coefficient in each of four parallel banks;
- a 32-bit rounding register;
- a limit register, which holds a 16-bit upper bound and a 16-bit lower bound.

The datapath reads the stored values through three independent select/read port groups. Those reads are combinational with the default settings.

Frames can follow each other with no gap while the strobe stays low. Capture is armed only when the strobe goes from high to low. A frame is committed in full on the edge of its last data word. A frame that is interrupted before that edge leaves no trace. Addresses outside the defined ranges still occupy a full frame.

Top module: `cfgld_top`

## Requirements
- R1: After reset every rounding register and every limit register reads zero on its read port.
- R2: While `load_n` is high at a rising edge of `cfg_clk`, no word is captured and no stored coefficient, rounding or limit value changes, whatever is on `cfg_word`.
- R3: Capture is armed only by a high-to-low transition of `load_n` that is seen across two clock edges after reset. If `load_n` is low when reset is released, nothing is captured until `load_n` has been high and then low again.
- R4: A frame is five captured words, an address followed by four data words. Address 0x000–0x0FF selects coefficient set n = address. Data word k (k = 0..3) is written in full, all 12 bits, to bank k of that set. Bank k appears on `coef_out[12k+11:12k]`.
- R5: Address 0x800–0x80F selects rounding register n = address − 0x800. Its 32-bit value is built from bits 7:0 of the four data words, first word in bits 7:0 and last word in bits 31:24. Bits 11:8 of each data word are ignored.
- R6: Address 0xC00–0xC0F selects limit register n = address − 0xC00. Its 32-bit value is packed as in R5. Bits 31:16 appear on `lmt_upper` and bits 15:0 on `lmt_lower`.
- R7: While `load_n` stays low, the word that follows a frame's fourth data word is taken as the address of the next frame.
- R8: A frame whose address lies in none of the three ranges takes up its four data words and writes nothing.
- R9: Raising `load_n` before a frame's fourth data word discards the partial frame with no write. The next capture after re-arming is an address.
- R10: A committed value appears on its read port from the clock edge that captured the frame's fourth data word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfg_clk | input | 1 | Configuration clock; words are captured on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_n | input | 1 | Active-low load strobe; a falling transition arms capture |
| cfg_word | input | 12 | Shared address/data word |
| coef_sel | input | 8 | Coefficient set index for the read port |
| coef_out | output | 48 | Four 12-bit coefficients of the selected set, bank 0 in the low bits |
| rnd_sel | input | 4 | Rounding register index for the read port |
| rnd_out | output | 32 | Selected rounding value |
| lmt_sel | input | 4 | Limit register index for the read port |
| lmt_upper | output | 16 | Upper bound of the selected limit register |
| lmt_lower | output | 16 | Lower bound of the selected limit register |

## Verification
Two events can fall on the same clock edge: the commit of one frame and the capture of the next frame's address, which happens during a back-to-back run. Likewise, a drop of `load_n` can coincide with the position of a fourth data word and so abandon a frame. The bench provokes both with random bursts of one to three chained frames. Some bursts end in a truncated frame whose data words are themselves valid-looking addresses. After each burst, every register the reference model touched is read back through the ports and compared with bench-computed packing. A misread boundary shows up either as a lost value or as a spurious write.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

   // Kind of storage a frame's address points at.
   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_COEF = 2'd1,
      TGT_RND  = 2'd2,
      TGT_LMT  = 2'd3
   } tgt_e;

endpackage

// File: rtl/cfgld_seq.sv
// Arming, word counting, address decode and frame assembly.
module cfgld_seq
   import cfgld_pkg::*;
#(
   parameter int WORD_W    = 12,
   parameter int N_DATA    = 4,
   parameter int N_SETS    = 256,
   parameter int N_RND     = 16,
   parameter int N_LMT     = 16,
   parameter int COEF_BASE = 'h000,
   parameter int RND_BASE  = 'h800,
   parameter int LMT_BASE  = 'hC00,
   parameter int IDX_W     = 8,
   parameter int PH_W      = 3
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             load_n,
   input  logic [WORD_W-1:0]                word,
   output logic                             capture_o,
   output logic [PH_W-1:0]                  phase_o,
   output logic                             wr_fire_o,
   output tgt_e                             wr_tgt_o,
   output logic [IDX_W-1:0]                 wr_idx_o,
   output logic [N_DATA-1:0][WORD_W-1:0]    wr_data_o
);

   localparam logic [PH_W-1:0] LAST_PH = PH_W'(N_DATA);

   logic                            prev_hi_q;
   logic                            armed_q;
   logic [PH_W-1:0]                 phase_q;
   tgt_e                            tgt_q;
   logic [IDX_W-1:0]                idx_q;
   logic [N_DATA-2:0][WORD_W-1:0]   hold_q;

   logic                            capture;
   tgt_e                            dec_tgt;
   logic [IDX_W-1:0]                dec_idx;
   logic [31:0]                     addr_ext;

   // Capture needs a previously seen high level, then stays armed while low.
   assign capture  = !load_n && (armed_q || prev_hi_q);
   assign addr_ext = 32'(word);

   always_comb begin
      dec_tgt = TGT_NONE;
      dec_idx = '0;
      if (addr_ext >= 32'(COEF_BASE) && addr_ext < 32'(COEF_BASE + N_SETS)) begin
         dec_tgt = TGT_COEF;
         dec_idx = IDX_W'(addr_ext - 32'(COEF_BASE));
      end else if (addr_ext >= 32'(RND_BASE) && addr_ext < 32'(RND_BASE + N_RND)) begin
         dec_tgt = TGT_RND;
         dec_idx = IDX_W'(addr_ext - 32'(RND_BASE));
      end else if (addr_ext >= 32'(LMT_BASE) && addr_ext < 32'(LMT_BASE + N_LMT)) begin
         dec_tgt = TGT_LMT;
         dec_idx = IDX_W'(addr_ext - 32'(LMT_BASE));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_hi_q <= 1'b0;
         armed_q   <= 1'b0;
         phase_q   <= '0;
         tgt_q     <= TGT_NONE;
         idx_q     <= '0;
         hold_q    <= '0;
      end else begin
         prev_hi_q <= load_n;
         armed_q   <= capture;
         if (!capture) begin
            phase_q <= '0;
         end else if (phase_q == '0) begin
            tgt_q   <= dec_tgt;
            idx_q   <= dec_idx;
            phase_q <= PH_W'(1);
         end else if (phase_q == LAST_PH) begin
            phase_q <= '0;
         end else begin
            for (int k = 0; k < N_DATA - 1; k++) begin
               if (phase_q == PH_W'(k + 1)) hold_q[k] <= word;
            end
            phase_q <= phase_q + PH_W'(1);
         end
      end
   end

   assign capture_o = capture;
   assign phase_o   = phase_q;
   assign wr_fire_o = capture && (phase_q == LAST_PH);
   assign wr_tgt_o  = tgt_q;
   assign wr_idx_o  = idx_q;

   for (genvar k = 0; k < N_DATA - 1; k++) begin : g_held
      assign wr_data_o[k] = hold_q[k];
   end
   assign wr_data_o[N_DATA-1] = word;

endmodule

// File: rtl/cfgld_coef_store.sv
// Parallel coefficient banks, one word per bank per set.
module cfgld_coef_store #(
   parameter int WORD_W   = 12,
   parameter int N_BANKS  = 4,
   parameter int N_SETS   = 256,
   parameter int IDX_W    = 8,
   parameter bit READ_REG = 1'b0
) (
   input  logic                             clk,
   input  logic                             we,
   input  logic [IDX_W-1:0]                 wr_idx,
   input  logic [N_BANKS-1:0][WORD_W-1:0]   wr_data,
   input  logic [IDX_W-1:0]                 rd_idx,
   output logic [N_BANKS-1:0][WORD_W-1:0]   rd_data
);

   for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
      logic [WORD_W-1:0] mem [N_SETS];

      always_ff @(posedge clk) begin
         if (we) mem[wr_idx] <= wr_data[b];
      end

      if (READ_REG) begin : g_rd_reg
         always_ff @(posedge clk) rd_data[b] <= mem[rd_idx];
      end else begin : g_rd_comb
         assign rd_data[b] = mem[rd_idx];
      end
   end

endmodule

// File: rtl/cfgld_ctl_regs.sv
// A file of wide control registers filled from packed frame words.
module cfgld_ctl_regs #(
   parameter int WORD_W   = 12,
   parameter int N_DATA   = 4,
   parameter int N_REGS   = 16,
   parameter int SEL_W    = 4,
   parameter int REG_W    = 32,
   parameter bit READ_REG = 1'b0
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             we,
   input  logic [SEL_W-1:0]                 wr_sel,
   input  logic [N_DATA-1:0][WORD_W-1:0]    wr_data,
   input  logic [SEL_W-1:0]                 rd_sel,
   output logic [REG_W-1:0]                 rd_data,
   output logic [N_REGS-1:0][REG_W-1:0]     all_o
);

   localparam int PACK_W = REG_W / N_DATA;

   logic [REG_W-1:0] packed_val;
   logic             unused_bits;

   // First data word lands in the least significant slice.
   for (genvar k = 0; k < N_DATA; k++) begin : g_pack
      assign packed_val[k*PACK_W +: PACK_W] = wr_data[k][PACK_W-1:0];
   end
   assign unused_bits = ^wr_data;

   for (genvar r = 0; r < N_REGS; r++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               all_o[r] <= '0;
         else if (we && wr_sel == SEL_W'(r))       all_o[r] <= packed_val;
      end
   end

   if (READ_REG) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rd_data <= '0;
         else        rd_data <= all_o[rd_sel];
      end
   end else begin : g_rd_comb
      assign rd_data = all_o[rd_sel];
   end

endmodule

// File: rtl/cfgld_top.sv
module cfgld_top
   import cfgld_pkg::*;
#(
   parameter int WORD_W    = 12,
   parameter int N_BANKS   = 4,
   parameter int N_SETS    = 256,
   parameter int N_RND     = 16,
   parameter int N_LMT     = 16,
   parameter int REG_W     = 32,
   parameter int COEF_BASE = 'h000,
   parameter int RND_BASE  = 'h800,
   parameter int LMT_BASE  = 'hC00,
   parameter bit READ_REG  = 1'b0
) (
   input  logic                        cfg_clk,
   input  logic                        rst_n,
   input  logic                        load_n,
   input  logic [WORD_W-1:0]           cfg_word,
   input  logic [$clog2(N_SETS)-1:0]   coef_sel,
   output logic [N_BANKS*WORD_W-1:0]   coef_out,
   input  logic [$clog2(N_RND)-1:0]    rnd_sel,
   output logic [REG_W-1:0]            rnd_out,
   input  logic [$clog2(N_LMT)-1:0]    lmt_sel,
   output logic [REG_W/2-1:0]          lmt_upper,
   output logic [REG_W/2-1:0]          lmt_lower
);

   localparam int IDX_W  = $clog2(N_SETS);
   localparam int RSEL_W = $clog2(N_RND);
   localparam int LSEL_W = $clog2(N_LMT);
   localparam int PACK_W = REG_W / N_BANKS;
   localparam int HALF_W = REG_W / 2;
   localparam int PH_W   = $clog2(N_BANKS + 1);

   // Elaboration-time parameter checks.
   if (N_BANKS < 2) begin : g_chk_banks
      $error("cfgld_top: N_BANKS must be at least 2");
   end
   if (REG_W % N_BANKS != 0 || PACK_W > WORD_W) begin : g_chk_pack
      $error("cfgld_top: REG_W must split evenly into slices no wider than a word");
   end
   if (N_RND > N_SETS || N_LMT > N_SETS) begin : g_chk_idx
      $error("cfgld_top: register files may not exceed the coefficient set count");
   end
   if ((1 << IDX_W) != N_SETS || (1 << RSEL_W) != N_RND || (1 << LSEL_W) != N_LMT) begin : g_chk_pow2
      $error("cfgld_top: storage depths must be powers of two");
   end
   if (REG_W % 2 != 0) begin : g_chk_half
      $error("cfgld_top: REG_W must be even");
   end

   logic                             capture;
   logic [PH_W-1:0]                  phase;
   logic                             wr_fire;
   tgt_e                             wr_tgt;
   logic [IDX_W-1:0]                 wr_idx;
   logic [N_BANKS-1:0][WORD_W-1:0]   wr_data;
   logic                             coef_we;
   logic                             rnd_we;
   logic                             lmt_we;
   logic [N_BANKS-1:0][WORD_W-1:0]   coef_rd;
   logic [N_RND-1:0][REG_W-1:0]      rnd_all;
   logic [N_LMT-1:0][REG_W-1:0]      lmt_all;
   logic [REG_W-1:0]                 lmt_rd;

   cfgld_seq #(
      .WORD_W(WORD_W), .N_DATA(N_BANKS), .N_SETS(N_SETS), .N_RND(N_RND),
      .N_LMT(N_LMT), .COEF_BASE(COEF_BASE), .RND_BASE(RND_BASE),
      .LMT_BASE(LMT_BASE), .IDX_W(IDX_W), .PH_W(PH_W)
   ) u_seq (
      .clk(cfg_clk), .rst_n(rst_n), .load_n(load_n), .word(cfg_word),
      .capture_o(capture), .phase_o(phase), .wr_fire_o(wr_fire),
      .wr_tgt_o(wr_tgt), .wr_idx_o(wr_idx), .wr_data_o(wr_data)
   );

   assign coef_we = wr_fire && (wr_tgt == TGT_COEF);
   assign rnd_we  = wr_fire && (wr_tgt == TGT_RND);
   assign lmt_we  = wr_fire && (wr_tgt == TGT_LMT);

   cfgld_coef_store #(
      .WORD_W(WORD_W), .N_BANKS(N_BANKS), .N_SETS(N_SETS),
      .IDX_W(IDX_W), .READ_REG(READ_REG)
   ) u_coef (
      .clk(cfg_clk), .we(coef_we), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_idx(coef_sel), .rd_data(coef_rd)
   );

   cfgld_ctl_regs #(
      .WORD_W(WORD_W), .N_DATA(N_BANKS), .N_REGS(N_RND), .SEL_W(RSEL_W),
      .REG_W(REG_W), .READ_REG(READ_REG)
   ) u_rnd (
      .clk(cfg_clk), .rst_n(rst_n), .we(rnd_we), .wr_sel(wr_idx[RSEL_W-1:0]),
      .wr_data(wr_data), .rd_sel(rnd_sel), .rd_data(rnd_out), .all_o(rnd_all)
   );

   cfgld_ctl_regs #(
      .WORD_W(WORD_W), .N_DATA(N_BANKS), .N_REGS(N_LMT), .SEL_W(LSEL_W),
      .REG_W(REG_W), .READ_REG(READ_REG)
   ) u_lmt (
      .clk(cfg_clk), .rst_n(rst_n), .we(lmt_we), .wr_sel(wr_idx[LSEL_W-1:0]),
      .wr_data(wr_data), .rd_sel(lmt_sel), .rd_data(lmt_rd), .all_o(lmt_all)
   );

   assign coef_out  = coef_rd;
   assign lmt_upper = lmt_rd[REG_W-1:HALF_W];
   assign lmt_lower = lmt_rd[HALF_W-1:0];

endmodule

// File: rtl/cfgld_chk.sv
module cfgld_chk #(
   parameter int N_DATA = 4,
   parameter int PH_W   = 3,
   parameter int N_RND  = 16,
   parameter int N_LMT  = 16,
   parameter int REG_W  = 32
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          load_n,
   input logic                          capture,
   input logic [PH_W-1:0]               phase,
   input logic                          coef_we,
   input logic                          rnd_we,
   input logic                          lmt_we,
   input logic [N_RND-1:0][REG_W-1:0]   rnd_all,
   input logic [N_LMT-1:0][REG_W-1:0]   lmt_all
);

   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load_n |=> ($stable(rnd_all) && $stable(lmt_all)));

   assert_arm_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (capture && !$past(capture)) |-> $past(load_n));

   assert_one_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({coef_we, rnd_we, lmt_we}));

   assert_phase_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      phase <= PH_W'(N_DATA));

   assert_frame_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (capture && phase == PH_W'(N_DATA)) |=> (phase == '0));

   assert_abort_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
      load_n |=> (phase == '0));

endmodule

bind cfgld_top cfgld_chk #(
   .N_DATA(N_BANKS), .PH_W(PH_W), .N_RND(N_RND), .N_LMT(N_LMT), .REG_W(REG_W)
) u_chk (
   .clk(cfg_clk), .rst_n(rst_n), .load_n(load_n), .capture(capture),
   .phase(phase), .coef_we(coef_we), .rnd_we(rnd_we), .lmt_we(lmt_we),
   .rnd_all(rnd_all), .lmt_all(lmt_all)
);

// File: tb/tb_cfgld_top.sv
`timescale 1ns/1ps
module tb_cfgld_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load_n = 1'b0;
   logic [11:0] cfg_word = '0;
   logic [7:0]  coef_sel = '0;
   logic [47:0] coef_out;
   logic [3:0]  rnd_sel = '0;
   logic [31:0] rnd_out;
   logic [3:0]  lmt_sel = '0;
   logic [15:0] lmt_upper;
   logic [15:0] lmt_lower;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [31:0] rnd_ref [16];
   logic [31:0] lmt_ref [16];
   logic [47:0] coef_ref [256];
   bit          coef_ok [256];

   always #2.5 clk = ~clk;

   cfgld_top dut (
      .cfg_clk(clk), .rst_n(rst_n), .load_n(load_n), .cfg_word(cfg_word),
      .coef_sel(coef_sel), .coef_out(coef_out), .rnd_sel(rnd_sel),
      .rnd_out(rnd_out), .lmt_sel(lmt_sel), .lmt_upper(lmt_upper),
      .lmt_lower(lmt_lower)
   );

   function automatic logic [31:0] pack32(input logic [11:0] d [4]);
      return {d[3][7:0], d[2][7:0], d[1][7:0], d[0][7:0]};
   endfunction

   function automatic logic [47:0] pack48(input logic [11:0] d [4]);
      return {d[3], d[2], d[1], d[0]};
   endfunction

   task automatic chk(input logic [47:0] act, input logic [47:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic ln, input logic [11:0] w);
      @(negedge clk);
      load_n   = ln;
      cfg_word = w;
   endtask

   // Reference model for a completed frame.
   task automatic apply(input logic [11:0] a, input logic [11:0] d [4]);
      if (a <= 12'h0FF) begin
         coef_ref[a[7:0]] = pack48(d);
         coef_ok[a[7:0]]  = 1'b1;
      end else if (a >= 12'h800 && a <= 12'h80F) begin
         rnd_ref[a[3:0]] = pack32(d);
      end else if (a >= 12'hC00 && a <= 12'hC0F) begin
         lmt_ref[a[3:0]] = pack32(d);
      end
   endtask

   // Drives a full frame with load low; caller arranges arming.
   task automatic frame(input logic [11:0] a, input logic [11:0] d [4]);
      drive(1'b0, a);
      for (int k = 0; k < 4; k++) drive(1'b0, d[k]);
      apply(a, d);
   endtask

   // Sample right after the negedge that follows the last data edge.
   task automatic chk_rnd(input int i, input string tag);
      rnd_sel = 4'(i); #1;
      chk({16'h0, rnd_out}, {16'h0, rnd_ref[i]}, tag);
   endtask

   task automatic chk_lmt(input int i, input string tag);
      lmt_sel = 4'(i); #1;
      chk({16'h0, lmt_upper, lmt_lower}, {16'h0, lmt_ref[i]}, tag);
   endtask

   task automatic chk_coef(input int i, input string tag);
      coef_sel = 8'(i); #1;
      chk(coef_out, coef_ref[i], tag);
   endtask

   function automatic logic [11:0] rand_addr();
      int unsigned c = $urandom % 4;
      case (c)
         0:       return 12'($urandom % 256);
         1:       return 12'h800 + 12'($urandom % 16);
         2:       return 12'hC00 + 12'($urandom % 16);
         default: return 12'h100 + 12'($urandom % 12'h700);
      endcase
   endfunction

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [11:0] d [4];
      void'($urandom(32'h5A17));
      for (int i = 0; i < 16; i++) begin rnd_ref[i] = '0; lmt_ref[i] = '0; end
      for (int i = 0; i < 256; i++) begin coef_ref[i] = '0; coef_ok[i] = 1'b0; end

      // R1: reset state, load held low through reset.
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk_rnd(5, "R1 rnd reset");
      chk_lmt(9, "R1 lmt reset");

      // R3: load low since reset is not an arming edge.
      d = '{12'h0AA, 12'h0BB, 12'h0CC, 12'h0DD};
      drive(1'b0, 12'h803);
      for (int k = 0; k < 4; k++) drive(1'b0, d[k]);
      drive(1'b1, 12'h000);
      chk_rnd(3, "R3 no arm without falling edge");

      // R4: coefficient set, full 12-bit words per bank.
      d = '{12'hF01, 12'hA52, 12'h3C3, 12'hFFF};
      frame(12'h0FF, d);
      drive(1'b1, 12'h000);
      chk_coef(255, "R4 coef set 255");
      chk(coef_out[23:12], 12'hA52, "R4 bank1 position");

      // R5 + R10: rounding, upper nibble ignored, visible right away.
      d = '{12'hF12, 12'hE34, 12'hD56, 12'hC78};
      frame(12'h80F, d);
      drive(1'b1, 12'h000);
      chk_rnd(15, "R10 rnd visible next cycle");
      chk({16'h0, rnd_out}, 48'h0000_7856_3412, "R5 packing");

      // R6: limit halves.
      d = '{12'h011, 12'h022, 12'h033, 12'h044};
      frame(12'hC00, d);
      drive(1'b1, 12'h000);
      chk_lmt(0, "R6 limit 0");
      chk({32'h0, lmt_upper}, 48'h4433, "R6 upper half");

      // R7 + R8: out-of-range frame chained before a real one; data look like addresses.
      d = '{12'h805, 12'h805, 12'hC05, 12'h805};
      frame(12'h7FF, d);
      d = '{12'h001, 12'h002, 12'h003, 12'h004};
      frame(12'h801, d);
      d = '{12'h111, 12'h122, 12'h133, 12'h144};
      frame(12'hC0E, d);
      drive(1'b1, 12'h000);
      chk_rnd(5, "R8 out-of-range writes nothing");
      chk_lmt(5, "R8 out-of-range lmt untouched");
      chk_rnd(1, "R7 chained frame 2");
      chk_lmt(14, "R7 chained frame 3");

      // R9: abort mid-frame, then a fresh frame starts at an address.
      drive(1'b0, 12'h802);
      drive(1'b0, 12'h0AB);
      drive(1'b0, 12'h0CD);
      drive(1'b0, 12'h0EF);
      drive(1'b1, 12'h801);
      d = '{12'h0A0, 12'h0B0, 12'h0C0, 12'h0D0};
      frame(12'h804, d);
      drive(1'b1, 12'h000);
      chk_rnd(2, "R9 aborted frame not written");
      chk_rnd(4, "R9 restart at address");

      // R2: words present while load high change nothing.
      for (int k = 0; k < 20; k++) drive(1'b1, 12'(k * 12'h0C1 + 12'h800));
      chk_rnd(15, "R2 idle rnd held");
      chk_lmt(0, "R2 idle lmt held");
      chk_coef(255, "R2 idle coef held");

      // Random bursts: chained frames, optional truncated tail.
      for (int b = 0; b < 400; b++) begin
         int nf = 1 + int'($urandom % 3);
         drive(1'b1, 12'($urandom));
         for (int f = 0; f < nf; f++) begin
            for (int k = 0; k < 4; k++) d[k] = 12'($urandom);
            frame(rand_addr(), d);
         end
         if ($urandom % 4 == 0) begin
            int nw = 1 + int'($urandom % 4);
            drive(1'b0, rand_addr());
            for (int k = 1; k < nw; k++) drive(1'b0, rand_addr());
         end
      end
      drive(1'b1, 12'h000);
      for (int i = 0; i < 16; i++) chk_rnd(i, "R5 R7 R9 random rnd");
      for (int i = 0; i < 16; i++) chk_lmt(i, "R6 R7 R9 random lmt");
      for (int i = 0; i < 256; i++) if (coef_ok[i]) chk_coef(i, "R4 R8 random coef");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule